// File: doc/BRIEF.md
# AC-link Serial Frame Receiver

This block turns the codec-to-controller serial stream of an AC-link into parallel words. It runs entirely on the falling edge of the bit clock and watches the frame sync line, which the controller drives. Each sync rising edge marks the start of a 256-bit frame: a 16-bit tag slot, then twelve 20-bit data slots, all sent most significant bit first.

During a frame the receiver fills a single shift register and copies out the five slots it cares about as each one completes. These are the codec status address, the codec status data, left and right PCM input and the microphone sample. When the final bit has been sampled it publishes the tag and those five fields together, each with a valid flag taken from the tag, and raises a one-cycle frame-done strobe. If sync rises again before a frame is complete, the partial frame is dropped and capture starts over.

Top module: `aclink_rx`

## Requirements
- R1: While rst_n is low, every output is zero, every valid flag is low and frame_done is low.
- R2: sdin is sampled only on falling bclk edges, and the first 16 bits of a frame land in tag_out in arrival order, the first bit in tag_out[15].
- R3: A frame starts at the first falling edge where sync is sampled high after having been sampled low. The sdin bit taken at that edge is tag bit 15.
- R4: Data slot k (k = 1 to 12) is made of frame bits 16+20(k-1) through 35+20(k-1), MSB first. Slot 1 is reported on stat_addr, slot 2 on stat_data, slot 3 on pcm_left, slot 4 on pcm_right and slot 6 on mic_pcm.
- R5: A field's valid flag is set at frame end only when tag bit 15 (frame valid) and tag bit 15-k (the valid bit for that field's slot k) are both 1.
- R6: A field whose valid condition is not met keeps the value it held before that frame.
- R7: frame_done is high for exactly one bclk cycle, beginning at the falling edge that samples the frame's 256th bit. tag_out, the fields and the flags change only at that edge.
- R8: If sync rises again before the 256th bit, the partial frame produces no frame_done and no output change, and the new edge starts a fresh frame.
- R9: The contents of slots 5 and 7 to 12 never affect any output.
- R10: If tag bit 15 is 0, all five valid flags are low after the frame, whatever the slot valid bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock. All state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame sync. A rising level marks the start of a frame |
| sdin | input | 1 | Serial data from the codec |
| tag_out | output | 16 | Tag slot of the last complete frame |
| stat_addr | output | 20 | Slot 1, codec status address |
| stat_addr_vld | output | 1 | stat_addr updated by the last frame |
| stat_data | output | 20 | Slot 2, codec status data |
| stat_data_vld | output | 1 | stat_data updated by the last frame |
| pcm_left | output | 20 | Slot 3, left PCM input |
| pcm_left_vld | output | 1 | pcm_left updated by the last frame |
| pcm_right | output | 20 | Slot 4, right PCM input |
| pcm_right_vld | output | 1 | pcm_right updated by the last frame |
| mic_pcm | output | 20 | Slot 6, microphone PCM input |
| mic_pcm_vld | output | 1 | mic_pcm updated by the last frame |
| frame_done | output | 1 | One-cycle strobe at the end of each complete frame |

## Verification
The assertions assume that sync and sdin change only away from the falling bclk edge. They also assume that sync returns low within the first frame so that each rising edge is a distinct start. The bench drives both inputs a nanosecond after the rising edge, and it holds sync high for only the 16 tag bits of each frame. The one deliberate deviation is a frame cut short at 100 bits by an early sync rise, which the restart property is written to accept.

// File: rtl/aclink_rx.sv
module aclink_rx #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic              sdin,
  output logic [TAG_W-1:0]  tag_out,
  output logic [SLOT_W-1:0] stat_addr,
  output logic              stat_addr_vld,
  output logic [SLOT_W-1:0] stat_data,
  output logic              stat_data_vld,
  output logic [SLOT_W-1:0] pcm_left,
  output logic              pcm_left_vld,
  output logic [SLOT_W-1:0] pcm_right,
  output logic              pcm_right_vld,
  output logic [SLOT_W-1:0] mic_pcm,
  output logic              mic_pcm_vld,
  output logic              frame_done
);

  localparam int FRAME_BITS = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int CW         = $clog2(FRAME_BITS + 1);
  localparam int NF         = 5;

  function automatic int field_slot(input int f);
    case (f)
      0:       return 1;
      1:       return 2;
      2:       return 3;
      3:       return 4;
      default: return 6;
    endcase
  endfunction

  logic [CW-1:0]     cnt;
  logic              active;
  logic              sync_q;
  logic [SLOT_W-1:0] shreg;
  logic [SLOT_W-1:0] sh_nxt;
  logic [TAG_W-1:0]  tag_hold;
  logic [NF-1:0]     fvld;

  wire start  = sync & ~sync_q;
  wire taking = active & ~start;
  wire last   = taking & (cnt == CW'(FRAME_BITS - 1));
  wire fr_ok  = tag_hold[TAG_W-1];

  assign sh_nxt = {shreg[SLOT_W-2:0], sdin};

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      active     <= 1'b0;
      sync_q     <= 1'b0;
      shreg      <= '0;
      frame_done <= 1'b0;
    end else begin
      sync_q     <= sync;
      frame_done <= last;
      if (start) begin
        cnt    <= CW'(1);
        active <= 1'b1;
        shreg  <= {{(SLOT_W-1){1'b0}}, sdin};
      end else if (active) begin
        shreg <= sh_nxt;
        if (last) begin
          cnt    <= '0;
          active <= 1'b0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      tag_hold <= '0;
      tag_out  <= '0;
    end else begin
      if (taking && cnt == CW'(TAG_W - 1))
        tag_hold <= sh_nxt[TAG_W-1:0];
      if (last)
        tag_out <= tag_hold;
    end
  end

  for (genvar f = 0; f < NF; f++) begin : g_fld
    localparam int SLOT = field_slot(f);
    localparam int ENDB = TAG_W + SLOT_W * SLOT - 1;
    logic [SLOT_W-1:0] hold_r;
    logic [SLOT_W-1:0] val_r;

    always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) begin
        hold_r  <= '0;
        val_r   <= '0;
        fvld[f] <= 1'b0;
      end else begin
        if (taking && cnt == CW'(ENDB))
          hold_r <= sh_nxt;
        if (last) begin
          if (fr_ok && tag_hold[TAG_W-1-SLOT]) begin
            val_r   <= hold_r;
            fvld[f] <= 1'b1;
          end else begin
            fvld[f] <= 1'b0;
          end
        end
      end
    end
  end

  assign stat_addr     = g_fld[0].val_r;
  assign stat_data     = g_fld[1].val_r;
  assign pcm_left      = g_fld[2].val_r;
  assign pcm_right     = g_fld[3].val_r;
  assign mic_pcm       = g_fld[4].val_r;
  assign stat_addr_vld = fvld[0];
  assign stat_data_vld = fvld[1];
  assign pcm_left_vld  = fvld[2];
  assign pcm_right_vld = fvld[3];
  assign mic_pcm_vld   = fvld[4];

  // R7
  done_pulse_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R7
  done_len_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    frame_done |-> $past(cnt) == CW'(FRAME_BITS - 1));

  // R7
  quiet_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    !frame_done |-> $stable({tag_out, fvld, stat_addr, stat_data, pcm_left, pcm_right, mic_pcm}));

  // R8
  restart_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    $rose(sync) |-> !frame_done);

  // R6
  keep_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    !pcm_right_vld |-> $stable(pcm_right));

  // R10
  fvalid_chk: assert property (@(negedge bclk) disable iff (!rst_n)
    (frame_done && (fvld != '0)) |-> tag_out[TAG_W-1]);

endmodule

// File: tb/aclink_rx_tb.sv
module aclink_rx_tb;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        sdin = 1'b0;
  logic [15:0] tag_out;
  logic [19:0] stat_addr, stat_data, pcm_left, pcm_right, mic_pcm;
  logic        stat_addr_vld, stat_data_vld, pcm_left_vld, pcm_right_vld, mic_pcm_vld;
  logic        frame_done;

  always #5 bclk = ~bclk;

  aclink_rx u_dut (
    .bclk(bclk), .rst_n(rst_n), .sync(sync), .sdin(sdin),
    .tag_out(tag_out),
    .stat_addr(stat_addr), .stat_addr_vld(stat_addr_vld),
    .stat_data(stat_data), .stat_data_vld(stat_data_vld),
    .pcm_left(pcm_left), .pcm_left_vld(pcm_left_vld),
    .pcm_right(pcm_right), .pcm_right_vld(pcm_right_vld),
    .mic_pcm(mic_pcm), .mic_pcm_vld(mic_pcm_vld),
    .frame_done(frame_done)
  );

  int checks = 0;
  int fails  = 0;
  int dcount = 0;
  int fs[5] = '{1, 2, 3, 4, 6};
  logic [19:0] slots [1:12];

  logic        q[$];
  logic        m_sp;
  logic        m_act;
  logic        m_done;
  logic [15:0] m_tag;
  logic [19:0] m_val [5];
  logic        m_vld [5];

  always @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_sp = 0; m_act = 0; m_done = 0; m_tag = 0;
      for (int f = 0; f < 5; f++) begin m_val[f] = 0; m_vld[f] = 0; end
    end else begin
      m_done = 0;
      if (sync && !m_sp) begin
        q.delete();
        q.push_back(sdin);
        m_act = 1;
      end else if (m_act) begin
        q.push_back(sdin);
        if (q.size() == 256) begin
          for (int i = 0; i < 16; i++) m_tag[15-i] = q[i];
          for (int f = 0; f < 5; f++) begin
            logic [19:0] v;
            for (int j = 0; j < 20; j++) v[19-j] = q[16 + 20*(fs[f]-1) + j];
            if (m_tag[15] && m_tag[15-fs[f]]) begin
              m_val[f] = v; m_vld[f] = 1;
            end else m_vld[f] = 0;
          end
          m_done = 1;
          m_act  = 0;
        end
      end
      m_sp = sync;
    end
  end

  always @(posedge bclk) if (rst_n && frame_done) dcount++;

  function automatic void chk(input string req, input string what,
                              input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endfunction

  function automatic void compare();
    logic [19:0] av [5];
    logic        ad [5];
    av = '{stat_addr, stat_data, pcm_left, pcm_right, mic_pcm};
    ad = '{stat_addr_vld, stat_data_vld, pcm_left_vld, pcm_right_vld, mic_pcm_vld};
    chk("R2", "tag_out", 32'(tag_out), 32'(m_tag));
    chk("R7", "frame_done", 32'(frame_done), 32'(m_done));
    for (int f = 0; f < 5; f++) begin
      chk("R4", $sformatf("field%0d value", f), 32'(av[f]), 32'(m_val[f]));
      chk("R5", $sformatf("field%0d valid", f), 32'(ad[f]), 32'(m_vld[f]));
    end
  endfunction

  task automatic step(input logic s, input logic d);
    @(posedge bclk);
    compare();
    #1;
    sync = s;
    sdin = d;
  endtask

  task automatic send_frame(input logic [15:0] tg, input int nbits);
    for (int b = 0; b < nbits; b++) begin
      if (b < 16) step(1'b1, tg[15-b]);
      else step(1'b0, slots[(b-16)/20 + 1][19 - (b-16)%20]);
    end
  endtask

  task automatic fill_slots();
    for (int k = 1; k <= 12; k++) slots[k] = 20'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge bclk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [19:0] a_right, d_addr, d_mic;
    logic [15:0] d_tag;
    int          dsave;

    repeat (3) @(posedge bclk);
    #1;
    // R1 reset state
    chk("R1", "tag_out", 32'(tag_out), 0);
    chk("R1", "fields", 32'(stat_addr | stat_data | pcm_left | pcm_right | mic_pcm), 0);
    chk("R1", "flags", 32'({stat_addr_vld, stat_data_vld, pcm_left_vld, pcm_right_vld, mic_pcm_vld, frame_done}), 0);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b1);

    // R3 R4 all valid
    fill_slots();
    send_frame(16'hFFF8, 256);
    step(1'b0, 1'b0);
    chk("R3", "tag captured", 32'(tag_out), 32'h0000FFF8);
    chk("R7", "done at end", 32'(frame_done), 1);
    chk("R4", "stat_addr slot1", 32'(stat_addr), 32'(slots[1]));
    chk("R4", "mic slot6", 32'(mic_pcm), 32'(slots[6]));
    a_right = slots[4];

    // R6 only slot 3 valid
    fill_slots();
    send_frame(16'h9000, 256);
    step(1'b0, 1'b0);
    chk("R5", "left valid", 32'(pcm_left_vld), 1);
    chk("R4", "left value", 32'(pcm_left), 32'(slots[3]));
    chk("R6", "right kept", 32'(pcm_right), 32'(a_right));
    chk("R6", "right flag low", 32'(pcm_right_vld), 0);

    // R10 frame-valid clear
    fill_slots();
    send_frame(16'h7FF8, 256);
    step(1'b0, 1'b0);
    chk("R10", "all flags low", 32'({stat_addr_vld, stat_data_vld, pcm_left_vld, pcm_right_vld, mic_pcm_vld}), 0);

    // R9 reserved slots ignored
    fill_slots();
    send_frame(16'hFFF8, 256);
    step(1'b0, 1'b0);
    d_addr = stat_addr; d_mic = mic_pcm; d_tag = tag_out;
    for (int k = 5; k <= 12; k++) if (k != 6) slots[k] = ~slots[k];
    send_frame(16'hFFF8, 256);
    step(1'b0, 1'b0);
    chk("R9", "addr unchanged", 32'(stat_addr), 32'(d_addr));
    chk("R9", "mic unchanged", 32'(mic_pcm), 32'(d_mic));
    chk("R9", "tag unchanged", 32'(tag_out), 32'(d_tag));

    // R8 truncated frame then restart
    dsave = dcount;
    fill_slots();
    send_frame(16'hFFF8, 100);
    fill_slots();
    send_frame(16'hF7F8, 256);
    step(1'b0, 1'b0);
    chk("R8", "one done for two starts", 32'(dcount - dsave), 1);
    chk("R8", "restart tag", 32'(tag_out), 32'h0000F7F8);
    chk("R8", "restart data", 32'(stat_data), 32'(slots[2]));
    chk("R5", "right flag from tag bit 11", 32'(pcm_right_vld), 0);
    repeat (5) step(1'b0, 1'b0);

    chk("R7", "total frames", 32'(dcount), 6);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule